// File: doc/BRIEF.md
# DMA Channel Interrupt Status Controller

This block gathers the event and error pulses of one DMA channel into a sticky interrupt status register. Each source has a fixed bit position. A per-bit enable mask selects which status bits drive a single registered interrupt line. Software reaches the status, mask and control registers through a small read/write port. Status bits are cleared by writing ones to them.

Most errors are non-fatal: they set a status bit and nothing else. A bus error on a data read or data write is handled differently. The block remembers the error but does not report it yet. It waits until the recovery logic signals that recovery is complete. At that point it sets the data error bit and drops the channel enable. Software can enable the channel again only after it has cleared both data error bits.

A pause event puts the channel into a paused state, which software can read, and a resume event leaves that state. The pause status bit is set only when software has enabled pause reporting.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, the status register, the mask, the control bits, `irq`, `chan_en` and `paused` are all zero.
- R2: A one-cycle pulse on a non-deferred source sets its status bit, and the bit reads 1 from the next cycle until it is cleared. The bit positions are: 1 source descriptor done, 2 destination descriptor done, 3 byte overflow, 4 source accounting overflow, 5 destination accounting overflow, 6 source descriptor fetch error, 7 destination descriptor fetch error, 10 transfer done, 12 data buffer parity, 13 free-slot parity, 14 linked-list parity. Bits 0 and 15 always read 0.
- R3: Sources other than the data errors never change `chan_en`.
- R4: A data read error (bit 8) or data write error (bit 9) does not appear in status until a `recov_done` pulse arrives. The bit is set by the same clock edge that samples `recov_done`.
- R5: When recovery completes for a pending data error, `chan_en` becomes 0 on that same edge.
- R6: A write to control with bit 0 = 1 sets `chan_en` only if status bits 8 and 9 are both 0. A write with bit 0 = 0 clears `chan_en`.
- R7: Writing to status clears each bit written as 1 and leaves each bit written as 0 unchanged. A hardware set in the same cycle as a clear wins.
- R8: `irq` equals the OR of (status AND mask) as it stood one cycle earlier.
- R9: `pause_evt` sets `paused` (control read bit 2) and `resume_evt` clears it. Status bit 11 is set by `pause_evt` only when control bit 1 (pause report enable) is 1.
- R10: The register addresses are 0 for status (write one to clear), 1 for mask (read/write) and 2 for control ({bit2 paused, read-only; bit1 pause report enable; bit0 channel enable}). `reg_rdata` shows the register selected by `reg_addr` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_dscr_done | input | 1 | Source descriptor completed |
| dst_dscr_done | input | 1 | Destination descriptor completed |
| byte_ovf | input | 1 | Byte count overflow |
| src_acct_ovf | input | 1 | Source accounting overflow |
| dst_acct_ovf | input | 1 | Destination accounting overflow |
| src_fetch_err | input | 1 | Bus error while fetching a source descriptor |
| dst_fetch_err | input | 1 | Bus error while fetching a destination descriptor |
| rd_data_err | input | 1 | Bus error on a data read (deferred) |
| wr_data_err | input | 1 | Bus error on a data write (deferred) |
| recov_done | input | 1 | Error recovery sequence complete |
| xfer_done | input | 1 | Transfer complete |
| pause_evt | input | 1 | Pause command taken |
| resume_evt | input | 1 | Channel resumed |
| parity_err | input | PAR_N | RAM parity errors: data buffer, free-slot index, linked list |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register select |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Combined masked interrupt |
| chan_en | output | 1 | Channel enable |
| paused | output | 1 | Channel pause state |

## Verification
A source pulse driven before edge N is visible in status from edge N onward, and `irq` follows at edge N+1. A register read returns data one edge after the address is applied. The bench drives stimulus on falling edges and waits the exact number of falling edges for each path before it samples: one for status and the control outputs, two for `irq`, one more for a read. For deferred data errors, the bench reads status several cycles after the error pulse and before `recov_done`. It then reads status and `chan_en` right after the recovery edge.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned B_SRC_DONE  = 1;
  localparam int unsigned B_DST_DONE  = 2;
  localparam int unsigned B_BYTE_OVF  = 3;
  localparam int unsigned B_SRC_ACCT  = 4;
  localparam int unsigned B_DST_ACCT  = 5;
  localparam int unsigned B_SRC_FETCH = 6;
  localparam int unsigned B_DST_FETCH = 7;
  localparam int unsigned B_RD_DATA   = 8;
  localparam int unsigned B_WR_DATA   = 9;
  localparam int unsigned B_DONE      = 10;
  localparam int unsigned B_PAUSE     = 11;
  localparam int unsigned B_PAR_BASE  = 12;
  localparam int unsigned CTRL_EN     = 0;
  localparam int unsigned CTRL_PIE    = 1;
  localparam int unsigned CTRL_PAUSED = 2;
endpackage

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status
);
  logic [W-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_vec : '0;

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= (status & ~clr_eff) | set_vec;
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));

  assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/dma_irq_recovery.sv
module dma_irq_recovery (
  input  logic clk,
  input  logic rst,
  input  logic rd_err,
  input  logic wr_err,
  input  logic recov_done,
  input  logic sw_en_we,
  input  logic sw_en_val,
  input  logic err_bits_clear,
  output logic rd_fire,
  output logic wr_fire,
  output logic chan_en
);
  logic pend_rd, pend_wr;

  assign rd_fire = recov_done & pend_rd;
  assign wr_fire = recov_done & pend_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_rd <= 1'b0;
      pend_wr <= 1'b0;
      chan_en <= 1'b0;
    end else begin
      if (rd_err)       pend_rd <= 1'b1;
      else if (rd_fire) pend_rd <= 1'b0;
      if (wr_err)       pend_wr <= 1'b1;
      else if (wr_fire) pend_wr <= 1'b0;
      if (rd_fire || wr_fire) chan_en <= 1'b0;
      else if (sw_en_we)      chan_en <= sw_en_val & err_bits_clear;
    end
  end

  assert_disable_on_recovery_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_fire || wr_fire) |=> !chan_en);

  assert_fire_needs_error_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_rd) |-> $past(rd_err));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned PAR_N  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_dscr_done,
  input  logic              dst_dscr_done,
  input  logic              byte_ovf,
  input  logic              src_acct_ovf,
  input  logic              dst_acct_ovf,
  input  logic              src_fetch_err,
  input  logic              dst_fetch_err,
  input  logic              rd_data_err,
  input  logic              wr_data_err,
  input  logic              recov_done,
  input  logic              xfer_done,
  input  logic              pause_evt,
  input  logic              resume_evt,
  input  logic [PAR_N-1:0]  parity_err,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              chan_en,
  output logic              paused
);
  import dma_irq_pkg::*;

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(2);

  logic [DATA_W-1:0] set_vec, status, mask_q;
  logic              pie_q, rd_fire, wr_fire;
  logic              wr_status, wr_mask, wr_ctrl;

  assign wr_status = reg_we && (reg_addr == A_STATUS);
  assign wr_mask   = reg_we && (reg_addr == A_MASK);
  assign wr_ctrl   = reg_we && (reg_addr == A_CTRL);

  always_comb begin
    set_vec = '0;
    set_vec[B_SRC_DONE]  = src_dscr_done;
    set_vec[B_DST_DONE]  = dst_dscr_done;
    set_vec[B_BYTE_OVF]  = byte_ovf;
    set_vec[B_SRC_ACCT]  = src_acct_ovf;
    set_vec[B_DST_ACCT]  = dst_acct_ovf;
    set_vec[B_SRC_FETCH] = src_fetch_err;
    set_vec[B_DST_FETCH] = dst_fetch_err;
    set_vec[B_RD_DATA]   = rd_fire;
    set_vec[B_WR_DATA]   = wr_fire;
    set_vec[B_DONE]      = xfer_done;
    set_vec[B_PAUSE]     = pause_evt & pie_q;
    for (int i = 0; i < PAR_N; i++) set_vec[B_PAR_BASE + i] = parity_err[i];
  end

  dma_irq_status #(.W(DATA_W)) u_status (
    .clk(clk), .rst(rst), .set_vec(set_vec),
    .clr_we(wr_status), .clr_vec(reg_wdata), .status(status)
  );

  dma_irq_recovery u_recov (
    .clk(clk), .rst(rst), .rd_err(rd_data_err), .wr_err(wr_data_err),
    .recov_done(recov_done), .sw_en_we(wr_ctrl), .sw_en_val(reg_wdata[CTRL_EN]),
    .err_bits_clear(!status[B_RD_DATA] && !status[B_WR_DATA]),
    .rd_fire(rd_fire), .wr_fire(wr_fire), .chan_en(chan_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      pie_q     <= 1'b0;
      paused    <= 1'b0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata;
      if (wr_ctrl) pie_q  <= reg_wdata[CTRL_PIE];
      if (pause_evt)       paused <= 1'b1;
      else if (resume_evt) paused <= 1'b0;
      irq <= |(status & mask_q);
      case (reg_addr)
        A_STATUS: reg_rdata <= status;
        A_MASK:   reg_rdata <= mask_q;
        A_CTRL:   reg_rdata <= DATA_W'({paused, pie_q, chan_en});
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assert_data_err_after_recovery_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(status[B_RD_DATA]) |-> $past(recov_done));

  assert_enable_by_write_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(chan_en) |-> $past(wr_ctrl && reg_wdata[CTRL_EN]));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq);

  assert_pause_source_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(paused) |-> $past(pause_evt));
endmodule

// File: tb/dma_irq_ctrl_test.sv
module dma_irq_ctrl_test;
  localparam int DW = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [10:0] ev = '0;
  logic rd_err = 0, wr_err = 0, rdone = 0, pev = 0, rev = 0;
  logic we = 0;
  logic [1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic irq, chan_en, paused;
  int checks = 0, errors = 0;
  bit finished = 0;
  int pos [11] = '{1, 2, 3, 4, 5, 6, 7, 10, 12, 13, 14};

  always #5 clk = ~clk;

  dma_irq_ctrl uut (
    .clk(clk), .rst(rst),
    .src_dscr_done(ev[0]), .dst_dscr_done(ev[1]), .byte_ovf(ev[2]),
    .src_acct_ovf(ev[3]), .dst_acct_ovf(ev[4]), .src_fetch_err(ev[5]),
    .dst_fetch_err(ev[6]), .rd_data_err(rd_err), .wr_data_err(wr_err),
    .recov_done(rdone), .xfer_done(ev[7]), .pause_evt(pev), .resume_evt(rev),
    .parity_err(ev[10:8]), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .irq(irq), .chan_en(chan_en), .paused(paused)
  );

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [DW-1:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [DW-1:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic pulse_ev(int i);
    ev[i] = 1'b1;
    @(negedge clk);
    ev[i] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", DW'(irq), 0);
    chk("R1 chan_en", DW'(chan_en), 0);
    chk("R1 paused", DW'(paused), 0);
    rd(0, d); chk("R1 status", d, 0);
    rd(1, d); chk("R1 mask", d, 0);
    rd(2, d); chk("R1 ctrl", d, 0);
    // R6 enable by write
    wr(2, 16'h0001);
    chk("R6 enable", DW'(chan_en), 1);
    rd(2, d); chk("R10 ctrl readback", d, 16'h0001);

    // R2 R3 R7 R8: sweep each non-deferred source
    for (int i = 0; i < 11; i++) begin
      logic [DW-1:0] b;
      b = DW'(1) << pos[i];
      wr(1, b);
      pulse_ev(i);
      chk("R3 chan_en kept", DW'(chan_en), 1);
      @(negedge clk);
      chk("R8 irq on masked bit", DW'(irq), 1);
      rd(0, d); chk("R2 bit position", d, b);
      wr(0, 16'h0000);
      rd(0, d); chk("R7 zero write keeps", d, b);
      wr(1, ~b);
      @(negedge clk); @(negedge clk);
      chk("R8 irq off unmasked", DW'(irq), 0);
      wr(0, b);
      rd(0, d); chk("R7 clear", d, 0);
    end
    rd(0, d); chk("R2 bits 0 and 15", d & 16'h8001, 0);

    // R7 set wins over clear
    ev[0] = 1; we = 1; addr = 0; wdata = 16'h0002;
    @(negedge clk);
    ev[0] = 0; we = 0;
    rd(0, d); chk("R7 set priority", d, 16'h0002);
    wr(0, 16'hFFFF);

    // R4 R5 deferred read error
    rd_err = 1; @(negedge clk); rd_err = 0;
    repeat (4) @(negedge clk);
    rd(0, d); chk("R4 deferred rd", d, 0);
    chk("R5 enabled before recovery", DW'(chan_en), 1);
    rdone = 1; @(negedge clk); rdone = 0;
    chk("R5 disabled", DW'(chan_en), 0);
    rd(0, d); chk("R4 rd bit8", d, 16'h0100);
    wr(2, 16'h0001);
    chk("R6 blocked while err", DW'(chan_en), 0);
    wr(0, 16'h0100);
    wr(2, 16'h0001);
    chk("R6 enable after clear", DW'(chan_en), 1);

    // R4 R5 deferred write error
    wr_err = 1; @(negedge clk); wr_err = 0;
    repeat (3) @(negedge clk);
    rd(0, d); chk("R4 deferred wr", d, 0);
    rdone = 1; @(negedge clk); rdone = 0;
    chk("R5 disabled wr", DW'(chan_en), 0);
    rd(0, d); chk("R4 wr bit9", d, 16'h0200);
    wr(0, 16'h0200);
    wr(2, 16'h0001);
    wr(2, 16'h0000);
    chk("R6 write zero clears", DW'(chan_en), 0);

    // R9 pause
    pev = 1; @(negedge clk); pev = 0;
    chk("R9 paused", DW'(paused), 1);
    rd(0, d); chk("R9 no bit11 when disabled", d, 0);
    rd(2, d); chk("R10 ctrl paused", d, 16'h0004);
    rev = 1; @(negedge clk); rev = 0;
    chk("R9 resumed", DW'(paused), 0);
    wr(2, 16'h0002);
    pev = 1; @(negedge clk); pev = 0;
    rd(0, d); chk("R9 bit11 when enabled", d, 16'h0800);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule